// File: doc/BRIEF.md
# Hardware Return Address Stack

This block holds the return addresses of a small processor core. It is a fixed-depth last-in, first-out store of program-counter values. A pointer marks the top entry, and a separate set of fast shadow registers saves the working register, the status byte and the bank-select value. The core's decoder presents one operation per cycle: absolute call, relative call, return, return-with-literal, return-from-interrupt, software push or software pop. The interrupt controller raises a one-cycle entry strobe. The block answers one cycle later with a program-counter load, shadow-restore enables, a literal load for the working register and global-interrupt-enable set pulses.

Every output is registered, so results appear one cycle after the edge that accepts the operation. A relative call occupies two cycles. In the cycle after it the block raises a bubble flag and ignores both the operation input and the interrupt strobe. Pushing onto a full stack or popping from an empty one sets a sticky flag, and the core keeps running. The stack contents and the pointer are then left as they were. The block has no streaming data path, so every pin is plain control or status and there is no back-pressure.

Top module: `rs_return_stack`

## Requirements
- R1: The operation code `op_i` is encoded as 0 none, 1 call, 2 relative call, 3 return, 4 return-with-literal, 5 return-from-interrupt, 6 push, 7 pop. Every output responds in the cycle after the accepting edge, and every output pulse lasts exactly one cycle. Code 0 produces no pulse.
- R2: A relative call pushes `pc_i+2` and loads `pc_i+2+2*off_i`, where `off_i` is an 11-bit two's-complement word offset and the sum wraps at 21 bits. In the following cycle `bubble_o` is 1, and any operation or interrupt strobe offered in that cycle has no effect.
- R3: An absolute call pushes `pc_i+4` and loads `tgt_i`. With `s_i`=1 it also captures `w_i`, `st_i` and `bsr_i` into the shadow outputs.
- R4: A return loads `pc_next_o` from the top entry and removes that entry. `rest_o` pulses only when `s_i`=1.
- R5: A return-with-literal pulses `wlit_load_o` with `wlit_o` equal to `lit_i`, loads the program counter from the top entry and removes it. It never pulses `rest_o`.
- R6: A return-from-interrupt loads the program counter from the top entry and removes it. It pulses `gieh_set_o` when `prio_i`=1 and `giel_set_o` when `prio_i`=0, never both together, and pulses `rest_o` when `s_i`=1.
- R7: A push stores `pc_i+2` as the new top entry, with the old top one level below it, and does not load the program counter.
- R8: A pop discards the top entry without loading the program counter, so the entry pushed before it becomes the top.
- R9: A push or call while 31 entries are held is dropped and leaves the stored entries unchanged. It sets `ovf_o`, which stays 1 until reset.
- R10: A pop or any return on an empty stack sets `unf_o`, which stays 1 until reset. A return in that case loads address 0.
- R11: `int_entry_i` pushes `pc_i` unchanged and captures `w_i`, `st_i` and `bsr_i` into the shadows in the same cycle. An operation offered in that same cycle is dropped.
- R12: Entries come back in exact reverse order of their insertion across the full depth.
- R13: After reset the stack is empty, and every pulse, both sticky flags and the shadow outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_i | input | 3 | Operation code |
| pc_i | input | 21 | Address of the current instruction |
| tgt_i | input | 21 | Absolute call target |
| off_i | input | 11 | Signed relative-call word offset |
| s_i | input | 1 | Fast shadow select |
| lit_i | input | 8 | Literal for return-with-literal |
| prio_i | input | 1 | Return-from-interrupt priority: 1 high, 0 low |
| int_entry_i | input | 1 | Interrupt entry strobe |
| w_i | input | 8 | Current working register |
| st_i | input | 5 | Current status byte |
| bsr_i | input | 4 | Current bank select |
| pc_load_o | output | 1 | Program-counter load pulse |
| pc_next_o | output | 21 | Address to load |
| bubble_o | output | 1 | Second cycle of a relative call |
| rest_o | output | 1 | Restore working, status and bank from the shadows |
| w_sh_o | output | 8 | Shadow working register |
| st_sh_o | output | 5 | Shadow status |
| bsr_sh_o | output | 4 | Shadow bank select |
| wlit_load_o | output | 1 | Working-register literal load pulse |
| wlit_o | output | 8 | Literal to load |
| gieh_set_o | output | 1 | Set high-priority global interrupt enable |
| giel_set_o | output | 1 | Set low-priority global interrupt enable |
| ovf_o | output | 1 | Sticky overflow |
| unf_o | output | 1 | Sticky underflow |

## Verification
The bench fills all 31 levels and pushes once more. It then checks that the extra push left the top entry intact, where a design that wrote past the end or wrapped its pointer would return the wrong address. It unwinds the stack to below empty, so a pointer that went negative would return stale data instead of address 0. Relative offsets are swept from -1024 to +1023, including a wrap at the top of the address space, and each call is followed by a push in the bubble cycle. A design without the bubble, or with a sign-extension error, would give a wrong return address or a wrong target. The bench also offers an interrupt strobe and a push together, then checks that only the interrupt's entry exists, and that return-from-interrupt raises exactly one enable of the chosen priority.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_CALL   = 3'd1,
    OP_RCALL  = 3'd2,
    OP_RET    = 3'd3,
    OP_RETLW  = 3'd4,
    OP_RETFIE = 3'd5,
    OP_PUSH   = 3'd6,
    OP_POP    = 3'd7
  } rs_op_e;
endpackage

// File: rtl/rs_lifo.sv
module rs_lifo #(
  parameter int DEPTH = 31,
  parameter int AW    = 21
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] din_i,
  output logic [AW-1:0] top_o,
  output logic          ovf_pulse_o,
  output logic          unf_pulse_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SPW-1:0] sp_q;
  logic           full, empty, do_push, do_pop;
  logic [AW-1:0]  ent [DEPTH];

  assign full    = (sp_q == SPW'(DEPTH));
  assign empty   = (sp_q == '0);
  assign do_push = push_i && !full;
  assign do_pop  = pop_i && !empty;
  assign ovf_pulse_o = push_i && full;
  assign unf_pulse_o = pop_i && empty;

  // one register per level, written only when the pointer sits on it
  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    logic [AW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= '0;
      else if (do_push && sp_q == SPW'(g))    q <= din_i;
    end
    assign ent[g] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sp_q <= '0;
    else if (do_push) sp_q <= sp_q + SPW'(1);
    else if (do_pop)  sp_q <= sp_q - SPW'(1);
  end

  logic [IW-1:0] top_idx;
  assign top_idx = IW'(sp_q - SPW'(1));
  assign top_o   = empty ? '0 : ent[top_idx];
endmodule

// File: rtl/rs_shadow.sv
module rs_shadow #(
  parameter int DW = 8,
  parameter int SW = 5,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_i,
  input  logic [DW-1:0] w_i,
  input  logic [SW-1:0] st_i,
  input  logic [BW-1:0] bsr_i,
  output logic [DW-1:0] w_o,
  output logic [SW-1:0] st_o,
  output logic [BW-1:0] bsr_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_o   <= '0;
      st_o  <= '0;
      bsr_o <= '0;
    end else if (cap_i) begin
      w_o   <= w_i;
      st_o  <= st_i;
      bsr_o <= bsr_i;
    end
  end
endmodule

// File: rtl/rs_addr_calc.sv
module rs_addr_calc
  import rs_pkg::*;
#(
  parameter int AW = 21,
  parameter int OW = 11
) (
  input  rs_op_e        op_i,
  input  logic          int_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [OW-1:0] off_i,
  input  logic [AW-1:0] top_i,
  output logic [AW-1:0] push_val_o,
  output logic [AW-1:0] jump_val_o
);
  localparam int PADW = AW - OW - 1;

  logic [AW-1:0] seq_pc, byte_off;
  assign seq_pc   = pc_i + AW'(2);
  assign byte_off = {{PADW{off_i[OW-1]}}, off_i, 1'b0};

  always_comb begin
    if (int_i)                push_val_o = pc_i;
    else if (op_i == OP_CALL) push_val_o = pc_i + AW'(4);
    else                      push_val_o = seq_pc;
  end

  always_comb begin
    unique case (op_i)
      OP_CALL:  jump_val_o = tgt_i;
      OP_RCALL: jump_val_o = seq_pc + byte_off;
      default:  jump_val_o = top_i;
    endcase
  end
endmodule

// File: rtl/rs_return_stack.sv
module rs_return_stack
  import rs_pkg::*;
#(
  parameter int DEPTH = 31,
  parameter int AW    = 21,
  parameter int OW    = 11,
  parameter int DW    = 8,
  parameter int SW    = 5,
  parameter int BW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] tgt_i,
  input  logic [OW-1:0] off_i,
  input  logic          s_i,
  input  logic [DW-1:0] lit_i,
  input  logic          prio_i,
  input  logic          int_entry_i,
  input  logic [DW-1:0] w_i,
  input  logic [SW-1:0] st_i,
  input  logic [BW-1:0] bsr_i,
  output logic          pc_load_o,
  output logic [AW-1:0] pc_next_o,
  output logic          bubble_o,
  output logic          rest_o,
  output logic [DW-1:0] w_sh_o,
  output logic [SW-1:0] st_sh_o,
  output logic [BW-1:0] bsr_sh_o,
  output logic          wlit_load_o,
  output logic [DW-1:0] wlit_o,
  output logic          gieh_set_o,
  output logic          giel_set_o,
  output logic          ovf_o,
  output logic          unf_o
);
  rs_op_e        opv;
  logic          intr, is_ret, is_jump, push, pop, cap;
  logic          ovf_p, unf_p;
  logic [AW-1:0] top, push_val, jump_val;

  // the bubble cycle after a relative call swallows everything
  always_comb begin
    intr = !bubble_o && int_entry_i;
    opv  = (!bubble_o && !int_entry_i) ? rs_op_e'(op_i) : OP_NONE;
  end

  assign is_ret  = (opv == OP_RET) || (opv == OP_RETLW) || (opv == OP_RETFIE);
  assign is_jump = is_ret || (opv == OP_CALL) || (opv == OP_RCALL);
  assign push    = intr || (opv == OP_CALL) || (opv == OP_RCALL) || (opv == OP_PUSH);
  assign pop     = is_ret || (opv == OP_POP);
  assign cap     = intr || ((opv == OP_CALL) && s_i);

  rs_lifo #(.DEPTH(DEPTH), .AW(AW)) u_lifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .pop_i      (pop),
    .din_i      (push_val),
    .top_o      (top),
    .ovf_pulse_o(ovf_p),
    .unf_pulse_o(unf_p)
  );

  rs_addr_calc #(.AW(AW), .OW(OW)) u_addr (
    .op_i      (opv),
    .int_i     (intr),
    .pc_i      (pc_i),
    .tgt_i     (tgt_i),
    .off_i     (off_i),
    .top_i     (top),
    .push_val_o(push_val),
    .jump_val_o(jump_val)
  );

  rs_shadow #(.DW(DW), .SW(SW), .BW(BW)) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .cap_i(cap),
    .w_i  (w_i),
    .st_i (st_i),
    .bsr_i(bsr_i),
    .w_o  (w_sh_o),
    .st_o (st_sh_o),
    .bsr_o(bsr_sh_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_load_o   <= 1'b0;
      pc_next_o   <= '0;
      bubble_o    <= 1'b0;
      rest_o      <= 1'b0;
      wlit_load_o <= 1'b0;
      wlit_o      <= '0;
      gieh_set_o  <= 1'b0;
      giel_set_o  <= 1'b0;
      ovf_o       <= 1'b0;
      unf_o       <= 1'b0;
    end else begin
      pc_load_o   <= is_jump;
      if (is_jump) pc_next_o <= jump_val;
      bubble_o    <= (opv == OP_RCALL);
      rest_o      <= ((opv == OP_RET) || (opv == OP_RETFIE)) && s_i;
      wlit_load_o <= (opv == OP_RETLW);
      if (opv == OP_RETLW) wlit_o <= lit_i;
      gieh_set_o  <= (opv == OP_RETFIE) && prio_i;
      giel_set_o  <= (opv == OP_RETFIE) && !prio_i;
      ovf_o       <= ovf_o || ovf_p;
      unf_o       <= unf_o || unf_p;
    end
  end
endmodule

// File: rtl/rs_checks.sv
module rs_checks #(
  parameter int AW = 21,
  parameter int OW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_i,
  input logic          int_entry_i,
  input logic          s_i,
  input logic          pc_load_o,
  input logic          bubble_o,
  input logic          rest_o,
  input logic          wlit_load_o,
  input logic          gieh_set_o,
  input logic          giel_set_o,
  input logic          ovf_o,
  input logic          unf_o
);
  // R2: accepted relative call opens a bubble, which lasts one cycle
  p_bubble_after_rcall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd2 && !bubble_o && !int_entry_i) |=> bubble_o);
  p_single_bubble_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_o |=> !bubble_o);
  // R7: an accepted push never loads the program counter
  p_push_no_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd6 && !bubble_o && !int_entry_i) |=> !pc_load_o);
  // R4: restore pulse only when a return with s set was accepted
  p_restore_needs_s_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd3 && !bubble_o && !int_entry_i && !s_i) |=> !rest_o);
  // R5: literal load only comes with a return
  p_wlit_with_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wlit_load_o |-> (pc_load_o && !rest_o));
  // R6: never both priority enables
  p_gie_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(gieh_set_o && giel_set_o));
  // R9 / R10: sticky flags
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);
  p_unf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unf_o |=> unf_o);
  // R1: pulses last one cycle when nothing follows
  p_idle_no_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == 3'd0 && !int_entry_i) |=> !pc_load_o);
endmodule

bind rs_return_stack rs_checks #(.AW(AW), .OW(OW), .DW(DW)) u_rs_checks (.*);

// File: tb/tb_rs_return_stack.sv
module tb_rs_return_stack;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 31;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_i = '0;
  logic [20:0] pc_i = '0, tgt_i = '0;
  logic [10:0] off_i = '0;
  logic        s_i = 1'b0, prio_i = 1'b0, int_entry_i = 1'b0;
  logic [7:0]  lit_i = '0, w_i = '0;
  logic [4:0]  st_i = '0;
  logic [3:0]  bsr_i = '0;
  logic        pc_load_o, bubble_o, rest_o, wlit_load_o, gieh_set_o, giel_set_o, ovf_o, unf_o;
  logic [20:0] pc_next_o;
  logic [7:0]  w_sh_o, wlit_o;
  logic [4:0]  st_sh_o;
  logic [3:0]  bsr_sh_o;

  int checks = 0, fails = 0;
  bit done = 0;

  rs_return_stack dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  // apply current inputs across one edge, sample at the next falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    op_i = 3'd0; int_entry_i = 1'b0; s_i = 1'b0;
  endtask

  function automatic logic [20:0] slot_pc(input int i);
    return 21'(32'h100 + i * 32'h40);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R13 reset state
    chk(!pc_load_o && !bubble_o && !rest_o && !wlit_load_o, "R13 pulses", {pc_load_o, bubble_o, rest_o, wlit_load_o}, 0);
    chk(!ovf_o && !unf_o && !gieh_set_o && !giel_set_o, "R13 flags", {ovf_o, unf_o, gieh_set_o, giel_set_o}, 0);
    chk(w_sh_o == 0 && st_sh_o == 0 && bsr_sh_o == 0, "R13 shadows", w_sh_o, 0);

    // R7 / R9 fill to depth, then one extra
    for (int i = 0; i < DEPTH; i++) begin
      op_i = 3'd6; pc_i = slot_pc(i); tick();
      if (pc_load_o) chk(0, "R7 push loaded pc", 1, 0);
    end
    chk(!ovf_o, "R9 no overflow at full", ovf_o, 0);
    op_i = 3'd6; pc_i = 21'h1ABCD; tick();
    chk(ovf_o, "R9 overflow flag", ovf_o, 1);
    op_i = 3'd3; tick();
    chk(pc_load_o && pc_next_o == slot_pc(30) + 2, "R9 top intact after overflow", pc_next_o, slot_pc(30) + 2);
    // R8 pop discards one
    op_i = 3'd7; tick();
    chk(!pc_load_o, "R8 pop no load", pc_load_o, 0);
    // R12 unwind remaining in reverse order
    for (int i = 28; i >= 0; i--) begin
      op_i = 3'd3; tick();
      chk(pc_load_o && pc_next_o == slot_pc(i) + 2, "R12 lifo order", pc_next_o, slot_pc(i) + 2);
    end
    chk(!unf_o, "R10 no underflow yet", unf_o, 0);
    op_i = 3'd3; tick();
    chk(unf_o && pc_next_o == 0, "R10 underflow returns 0", pc_next_o, 0);
    tick();
    chk(!pc_load_o && unf_o && ovf_o, "R1 single pulse / sticky", {pc_load_o, unf_o, ovf_o}, 3);

    // R2 relative call sweep
    for (int k = 0; k < 18; k++) begin
      int off;
      logic [20:0] base, exp_t;
      off  = (k == 16) ? 1023 : (k == 17) ? -1 : -1024 + k * 136;
      base = (k % 3 == 0) ? 21'h1FFFFC : 21'h04000 + 21'(k * 6);
      exp_t = 21'(32'(base) + 2 + 2 * off);
      op_i = 3'd2; pc_i = base; off_i = 11'(off); tick();
      chk(pc_load_o && pc_next_o == exp_t, "R2 target", pc_next_o, exp_t);
      chk(bubble_o, "R2 bubble", bubble_o, 1);
      op_i = 3'd6; pc_i = 21'h155; int_entry_i = 1'b1; tick();
      chk(!pc_load_o && !bubble_o, "R2 bubble op ignored", {pc_load_o, bubble_o}, 0);
      op_i = 3'd3; tick();
      chk(pc_next_o == 21'(base + 2), "R2 return address", pc_next_o, 21'(base + 2));
    end

    // R3 call with shadow capture, R4 return with restore
    w_i = 8'hA5; st_i = 5'h13; bsr_i = 4'h9;
    op_i = 3'd1; s_i = 1'b1; pc_i = 21'h00200; tgt_i = 21'h0F00A; tick();
    chk(pc_load_o && pc_next_o == 21'h0F00A, "R3 call target", pc_next_o, 21'h0F00A);
    chk(w_sh_o == 8'hA5 && st_sh_o == 5'h13 && bsr_sh_o == 4'h9, "R3 shadow capture", {w_sh_o, st_sh_o, bsr_sh_o}, {8'hA5, 5'h13, 4'h9});
    w_i = 8'h11; st_i = 5'h02; bsr_i = 4'h1;
    op_i = 3'd3; s_i = 1'b1; tick();
    chk(pc_next_o == 21'h00204 && rest_o, "R4 return s=1", {pc_next_o, rest_o}, {21'h00204, 1'b1});
    chk(w_sh_o == 8'hA5, "R3 shadow held", w_sh_o, 8'hA5);
    op_i = 3'd1; s_i = 1'b0; pc_i = 21'h00300; tick();
    chk(w_sh_o == 8'hA5, "R3 s=0 no capture", w_sh_o, 8'hA5);
    op_i = 3'd3; s_i = 1'b0; tick();
    chk(pc_next_o == 21'h00304 && !rest_o, "R4 return s=0", {pc_next_o, rest_o}, {21'h00304, 1'b0});

    // R5 return with literal
    for (int v = 0; v < 256; v += 51) begin
      op_i = 3'd6; pc_i = 21'(32'h7000 + v); tick();
      op_i = 3'd4; lit_i = 8'(v); s_i = 1'b1; tick();
      chk(wlit_load_o && wlit_o == 8'(v) && !rest_o, "R5 literal", wlit_o, 8'(v));
      chk(pc_next_o == 21'(32'h7002 + v), "R5 return address", pc_next_o, 21'(32'h7002 + v));
    end

    // R11 interrupt entry beats a push, R6 both priorities
    for (int p = 0; p < 2; p++) begin
      w_i = 8'(8'h30 + p); st_i = 5'(p + 4); bsr_i = 4'(p + 2);
      op_i = 3'd6; int_entry_i = 1'b1; pc_i = 21'(32'h9000 + p * 16); tick();
      chk(w_sh_o == 8'(8'h30 + p) && bsr_sh_o == 4'(p + 2), "R11 shadow capture", w_sh_o, 8'(8'h30 + p));
      op_i = 3'd5; prio_i = p[0]; s_i = p[0]; tick();
      chk(pc_next_o == 21'(32'h9000 + p * 16), "R11 pc pushed unchanged", pc_next_o, 21'(32'h9000 + p * 16));
      chk(gieh_set_o == p[0] && giel_set_o == !p[0], "R6 enable select", {gieh_set_o, giel_set_o}, {p[0], !p[0]});
      chk(rest_o == p[0], "R6 restore follows s", rest_o, p[0]);
      op_i = 3'd3; tick();
      chk(pc_next_o == 0, "R11 same-cycle push dropped", pc_next_o, 0);
    end

    // R1 idle produces nothing
    tick();
    chk(!pc_load_o && !wlit_load_o && !gieh_set_o && !giel_set_o && !rest_o, "R1 idle",
        {pc_load_o, wlit_load_o, gieh_set_o, giel_set_o, rest_o}, 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule